// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a down-counting watchdog that software must service inside a chosen part of each count period. A prescaler divides the peripheral clock into ticks. Each tick lowers a 16-bit counter, and the reload value is picked from four period lengths. The period is cut into four equal quarters, and a 4-bit mask selects the quarters in which servicing is allowed. The allowed quarters need not be next to each other. A service request outside the allowed quarters is a fault, just as letting the counter run out is.

Software configures the block through a control word, services it through a two-step key port, and reads back the live count and two sticky flags. Each flag can be cleared separately. Both kinds of fault go either to a level interrupt or to a one-cycle reset request. A sleep input can freeze the counter when the control word asks for that. The configuration locks once the first service request starts the counter.

Top module: `win_watchdog`

## Requirements
- R1: The control word holds the period code in bits [1:0], the divider code in [5:2], the quarter mask in [9:6], the sleep-hold bit in [10] and the reset-route bit in [11]; period codes 0, 1, 2 and 3 select reload values 255, 4095, 16383 and 65535, and an accepted control write loads the count output with that value.
- R2: Divider codes 2, 6, 7, 8, 9, 10, 11 and 13 give one tick every 4, 64, 128, 256, 512, 1024, 2048 and 8192 clocks counted from the start or last accepted service; a control write carrying any other divider code is ignored entirely.
- R3: Out of reset the count output is 255, both flags and both event outputs are low, and the counter holds until the first service request; after that it falls by one on every tick.
- R4: A service request is the key value 16'h0123 followed by 16'h3210 on the key port, with no other key write in between; any other key write cancels a pending 16'h0123.
- R5: With elapsed = reload value − count, the quarter is elapsed·4 / period (integer), so an elapsed value on a quarter boundary belongs to the upper quarter; mask bit n allows quarter n, and a mask of zero allows every quarter.
- R6: A service request in an allowed quarter reloads the counter and restarts the tick phase; one in a blocked quarter sets the refresh-error flag and leaves the count unchanged.
- R7: A tick with the count at zero sets the underflow flag and reloads the counter, one full period of ticks after the last reload.
- R8: With the sleep-hold bit set, the count does not change while sleep_i is high; with it clear, sleep_i has no effect.
- R9: Control writes after counting has started are ignored until reset.
- R10: With the reset-route bit clear, irq_o is high exactly while either flag is set, and rst_req_o stays low.
- R11: With the reset-route bit set, each fault gives a one-cycle pulse on rst_req_o in the cycle after the fault, and irq_o stays low.
- R12: Flags are sticky; clear-port bit 0 clears the underflow flag and bit 1 clears the refresh-error flag, each without disturbing the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low reset |
| sleep_i | input | 1 | Sleep mode indication |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 12 | Control word |
| key_we | input | 1 | Key port write strobe |
| key_wdata | input | 16 | Key value |
| clr_we | input | 1 | Flag clear strobe |
| clr_wdata | input | 2 | Per-flag clear bits |
| count_o | output | 16 | Live count value |
| underflow_flag_o | output | 1 | Sticky underflow flag |
| refresh_err_flag_o | output | 1 | Sticky refresh-error flag |
| irq_o | output | 1 | Level interrupt request |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
The bench sweeps all sixteen quarter masks. For each mask it places a service request exactly on each quarter boundary and one tick before it. A design that puts a boundary in the lower quarter, or that reads a zero mask as "never allowed", would flag or accept the wrong one of each pair. It also measures the tick interval for every divider code and tries every reserved code. A wrong decode would show up as a mismatched interval or as a reserved write that reloads the count. Broken key sequences, control writes after the start, sleep freezing and the exact cycle of the underflow are checked as well. An off-by-one reload or prescaler phase would move the underflow by a cycle, and the single-cycle reset pulse would be missed.

// File: rtl/win_watchdog.sv
module win_watchdog #(
  parameter logic [15:0] KEY_ARM  = 16'h0123,
  parameter logic [15:0] KEY_FIRE = 16'h3210,
  parameter int          DIV_W    = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sleep_i,
  input  logic        ctrl_we,
  input  logic [11:0] ctrl_wdata,
  input  logic        key_we,
  input  logic [15:0] key_wdata,
  input  logic        clr_we,
  input  logic [1:0]  clr_wdata,
  output logic [15:0] count_o,
  output logic        underflow_flag_o,
  output logic        refresh_err_flag_o,
  output logic        irq_o,
  output logic        rst_req_o
);

  localparam logic [11:0] CFG_RST = 12'h008;

  function automatic logic [3:0] div_shift(input logic [3:0] c);
    case (c)
      4'd2:    return 4'd2;
      4'd6:    return 4'd6;
      4'd7:    return 4'd7;
      4'd8:    return 4'd8;
      4'd9:    return 4'd9;
      4'd10:   return 4'd10;
      4'd11:   return 4'd11;
      4'd13:   return 4'd13;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic div_ok(input logic [3:0] c);
    return (c == 4'd2) || (c >= 4'd6 && c <= 4'd11) || (c == 4'd13);
  endfunction

  function automatic logic [15:0] top_of(input logic [1:0] p);
    case (p)
      2'd0:    return 16'h00FF;
      2'd1:    return 16'h0FFF;
      2'd2:    return 16'h3FFF;
      default: return 16'hFFFF;
    endcase
  endfunction

  logic [11:0]      cfg_q;
  logic [15:0]      count_q;
  logic [DIV_W-1:0] div_q;
  logic             run_q, armed_q, uf_q, re_q, rst_q;

  logic [15:0]      period_m1, elapsed;
  logic [1:0]       quarter;
  logic [3:0]       win_mask;
  logic [DIV_W-1:0] div_mask;
  logic             tick, advance, cfg_ok, fire, in_win, reload, ref_err, uf_evt;

  assign period_m1 = top_of(cfg_q[1:0]);
  assign elapsed   = period_m1 - count_q;
  assign win_mask  = cfg_q[9:6];

  always_comb begin
    case (cfg_q[1:0])
      2'd0:    quarter = elapsed[7:6];
      2'd1:    quarter = elapsed[11:10];
      2'd2:    quarter = elapsed[13:12];
      default: quarter = elapsed[15:14];
    endcase
  end

  assign div_mask = DIV_W'((32'd1 << div_shift(cfg_q[5:2])) - 32'd1);
  assign tick     = (div_q & div_mask) == div_mask;
  assign advance  = run_q && tick && !(sleep_i && cfg_q[10]);
  assign cfg_ok   = ctrl_we && !run_q && div_ok(ctrl_wdata[5:2]);
  assign fire     = key_we && (key_wdata == KEY_FIRE) && armed_q && !cfg_ok;
  assign in_win   = (win_mask == 4'd0) || win_mask[quarter];
  assign reload   = fire && (!run_q || in_win);
  assign ref_err  = fire && run_q && !in_win;
  assign uf_evt   = advance && (count_q == 16'd0) && !reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= CFG_RST;
      count_q <= top_of(CFG_RST[1:0]);
      div_q   <= '0;
      run_q   <= 1'b0;
      armed_q <= 1'b0;
      uf_q    <= 1'b0;
      re_q    <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      div_q <= reload ? '0 : div_q + 1'b1;
      if (key_we) armed_q <= (key_wdata == KEY_ARM);
      if (cfg_ok) begin
        cfg_q   <= ctrl_wdata;
        count_q <= top_of(ctrl_wdata[1:0]);
      end else if (reload) begin
        count_q <= period_m1;
        run_q   <= 1'b1;
      end else if (uf_evt) begin
        count_q <= period_m1;
      end else if (advance) begin
        count_q <= count_q - 16'd1;
      end
      if (uf_evt) uf_q <= 1'b1;
      else if (clr_we && clr_wdata[0]) uf_q <= 1'b0;
      if (ref_err) re_q <= 1'b1;
      else if (clr_we && clr_wdata[1]) re_q <= 1'b0;
      rst_q <= (uf_evt || ref_err) && cfg_q[11];
    end
  end

  assign count_o            = count_q;
  assign underflow_flag_o   = uf_q;
  assign refresh_err_flag_o = re_q;
  assign irq_o              = !cfg_q[11] && (uf_q || re_q);
  assign rst_req_o          = rst_q;

endmodule

// File: rtl/win_watchdog_chk.sv
module win_watchdog_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sleep_i,
  input logic        ctrl_we,
  input logic        key_we,
  input logic [15:0] count_o,
  input logic        underflow_flag_o,
  input logic        refresh_err_flag_o,
  input logic        irq_o,
  input logic        rst_req_o,
  input logic        run,
  input logic        advance,
  input logic        reload,
  input logic [11:0] cfg,
  input logic [15:0] period_m1
);

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !ctrl_we |=> $stable(count_o)); // R3

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    run && advance && !reload && count_o != 16'd0 |=> count_o == $past(count_o) - 16'd1); // R3

  AST_UF_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underflow_flag_o) |-> count_o == period_m1); // R7

  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    run && sleep_i && cfg[10] && !key_we |=> $stable(count_o)); // R8

  AST_CFG_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    run && ctrl_we |=> $stable(cfg)); // R9

  AST_IRQ_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (underflow_flag_o || refresh_err_flag_o)); // R10

  AST_RST_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> !irq_o && (underflow_flag_o || refresh_err_flag_o)); // R11

endmodule

bind win_watchdog win_watchdog_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .ctrl_we(ctrl_we), .key_we(key_we),
  .count_o(count_o), .underflow_flag_o(underflow_flag_o),
  .refresh_err_flag_o(refresh_err_flag_o), .irq_o(irq_o), .rst_req_o(rst_req_o),
  .run(run_q), .advance(advance), .reload(reload), .cfg(cfg_q), .period_m1(period_m1)
);

// File: tb/win_watchdog_test.sv
module win_watchdog_test;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sleep_i = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [11:0] ctrl_wdata = '0;
  logic        key_we = 1'b0;
  logic [15:0] key_wdata = '0;
  logic        clr_we = 1'b0;
  logic [1:0]  clr_wdata = '0;
  logic [15:0] count_o;
  logic        underflow_flag_o, refresh_err_flag_o, irq_o, rst_req_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  win_watchdog uut (
    .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .key_we(key_we), .key_wdata(key_wdata),
    .clr_we(clr_we), .clr_wdata(clr_wdata),
    .count_o(count_o), .underflow_flag_o(underflow_flag_o),
    .refresh_err_flag_o(refresh_err_flag_o), .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  always #(CLK_NS/2) clk = ~clk;

  function automatic logic [11:0] mk(input int per, input int dv, input int msk,
                                     input bit hold, input bit rmode);
    return {rmode, hold, 4'(msk), 4'(dv), 2'(per)};
  endfunction

  function automatic int exp_div(input int code);
    case (code)
      2: return 4;     6: return 64;    7: return 128;   8: return 256;
      9: return 512;   10: return 1024; 11: return 2048; 13: return 8192;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reset_dut();
    rst_n = 1'b0; sleep_i = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic key(input logic [15:0] d);
    key_we = 1'b1; key_wdata = d;
    @(negedge clk);
    key_we = 1'b0;
  endtask

  task automatic ctrl(input logic [11:0] d);
    ctrl_we = 1'b1; ctrl_wdata = d;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic clr(input logic [1:0] d);
    clr_we = 1'b1; clr_wdata = d;
    @(negedge clk);
    clr_we = 1'b0;
  endtask

  task automatic start();
    key(16'h0123); key(16'h3210);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_NS * 300000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    reset_dut();
    // R3 reset state
    chk(count_o == 16'd255, "R3 reset count", count_o, 255);
    chk(!underflow_flag_o && !refresh_err_flag_o, "R3 reset flags",
        {underflow_flag_o, refresh_err_flag_o}, 0);
    chk(!irq_o && !rst_req_o, "R3 reset outputs", {irq_o, rst_req_o}, 0);
    wait_n(50);
    chk(count_o == 16'd255, "R3 idle before start", count_o, 255);

    // R1 period codes
    for (int p = 0; p < 4; p++) begin
      int expv;
      expv = (p == 0) ? 255 : (p == 1) ? 4095 : (p == 2) ? 16383 : 65535;
      ctrl(mk(p, 2, 0, 0, 0));
      chk(count_o == 16'(expv), "R1 period load", count_o, expv);
    end

    // R2 divider sweep, reserved codes ignored
    for (int c = 0; c < 16; c++) begin
      reset_dut();
      if (exp_div(c) == 0) begin
        ctrl(mk(1, c, 0, 0, 0));
        chk(count_o == 16'd255, "R2 reserved divider ignored", count_o, 255);
      end else begin
        int m;
        ctrl(mk(0, c, 0, 0, 0));
        start();
        m = 0;
        while (count_o == 16'd255 && m < 10000) begin @(negedge clk); m++; end
        chk(m == exp_div(c), "R2 tick interval", m, exp_div(c));
      end
    end

    // R4 key sequences
    reset_dut();
    key(16'h3210); wait_n(20);
    chk(count_o == 16'd255, "R4 lone second key", count_o, 255);
    key(16'h0123); key(16'h5555); key(16'h3210); wait_n(20);
    chk(count_o == 16'd255, "R4 interrupted key", count_o, 255);
    key(16'h0123); key(16'h0123); key(16'h3210); wait_n(20);
    chk(count_o == 16'd250, "R4 R3 rearmed key starts counter", count_o, 250);

    // R9 control lock after start
    reset_dut();
    ctrl(mk(0, 2, 0, 0, 0));
    start();
    ctrl(mk(3, 13, 0, 0, 1));
    wait_n(11);
    chk(count_o == 16'd252, "R9 control write after start ignored", count_o, 252);

    // R5 R6 window sweep: every mask, each quarter boundary and one tick before
    for (int msk = 0; msk < 16; msk++) begin
      for (int q = 0; q < 4; q++) begin
        for (int side = 0; side < 2; side++) begin
          if (!(q == 0 && side == 1)) begin
            int target, e, qq, g;
            bit allow;
            reset_dut();
            ctrl(mk(0, 2, msk, 0, 0));
            start();
            key(16'h0123);
            target = 255 - q * 64 + side;
            g = 0;
            while (count_o != 16'(target) && g < 2000) begin @(negedge clk); g++; end
            key(16'h3210);
            e = 255 - target;
            qq = (e * 4) / 256;
            allow = (msk == 0) || msk[qq];
            if (allow) begin
              chk(!refresh_err_flag_o, "R5 allowed quarter no error", refresh_err_flag_o, 0);
              chk(count_o == 16'd255, "R6 allowed refresh reloads", count_o, 255);
            end else begin
              chk(refresh_err_flag_o && irq_o, "R5 R10 blocked quarter error",
                  {refresh_err_flag_o, irq_o}, 3);
              chk(count_o == 16'(target), "R6 blocked refresh keeps count", count_o, target);
            end
          end
        end
      end
    end

    // R7 R10 underflow in interrupt mode, R12 individual clears
    begin
      int m;
      reset_dut();
      ctrl(mk(0, 2, 1, 0, 0));
      start();
      key(16'h0123);
      while (count_o != 16'd191) @(negedge clk);
      key(16'h3210);
      chk(refresh_err_flag_o == 1'b1, "R12 error flag set", refresh_err_flag_o, 1);
      reset_dut();
      ctrl(mk(0, 2, 0, 0, 0));
      start();
      m = 0;
      while (!underflow_flag_o && m < 3000) begin @(negedge clk); m++; end
      chk(m == 1024, "R7 underflow timing", m, 1024);
      chk(count_o == 16'd255, "R7 reload after underflow", count_o, 255);
      chk(irq_o && !rst_req_o, "R10 irq level on underflow", {irq_o, rst_req_o}, 2);
      key(16'h0123);
      while (count_o != 16'd250) @(negedge clk);
      ctrl(mk(0, 2, 1, 0, 0));
      clr(2'b00);
      chk(underflow_flag_o && irq_o, "R12 flag sticky", underflow_flag_o, 1);
      clr(2'b01);
      chk(!underflow_flag_o && !irq_o, "R12 R10 clear underflow", underflow_flag_o, 0);
    end

    // R12 both flags, clear one at a time
    begin
      reset_dut();
      ctrl(mk(0, 2, 1, 0, 0));
      start();
      key(16'h0123);
      while (count_o != 16'd191) @(negedge clk);
      key(16'h3210);
      while (!underflow_flag_o) @(negedge clk);
      clr(2'b01);
      chk(!underflow_flag_o && refresh_err_flag_o && irq_o, "R12 clear bit0 only",
          {underflow_flag_o, refresh_err_flag_o, irq_o}, 3);
      clr(2'b10);
      chk(!refresh_err_flag_o && !irq_o, "R12 R10 clear bit1",
          {refresh_err_flag_o, irq_o}, 0);
    end

    // R11 reset route
    begin
      int m;
      bit irq_seen;
      reset_dut();
      ctrl(mk(0, 2, 0, 0, 1));
      start();
      m = 0; irq_seen = 1'b0;
      while (!rst_req_o && m < 3000) begin
        @(negedge clk); m++;
        if (irq_o) irq_seen = 1'b1;
      end
      chk(m == 1024, "R11 reset pulse timing", m, 1024);
      chk(!irq_seen && !irq_o, "R11 irq held low", irq_o, 0);
      chk(underflow_flag_o, "R11 R7 flag set in reset route", underflow_flag_o, 1);
      @(negedge clk);
      chk(!rst_req_o, "R11 single cycle pulse", rst_req_o, 0);
      reset_dut();
      ctrl(mk(0, 2, 8, 0, 1));
      start();
      key(16'h0123);
      key(16'h3210);
      chk(rst_req_o && !irq_o, "R11 refresh error pulse", {rst_req_o, irq_o}, 2);
      @(negedge clk);
      chk(!rst_req_o, "R11 error pulse single cycle", rst_req_o, 0);
    end

    // R8 sleep hold
    reset_dut();
    sleep_i = 1'b1;
    ctrl(mk(0, 2, 0, 1, 0));
    start();
    wait_n(100);
    chk(count_o == 16'd255, "R8 frozen in sleep", count_o, 255);
    sleep_i = 1'b0;
    wait_n(8);
    chk(count_o == 16'd253, "R8 resumes after sleep", count_o, 253);
    reset_dut();
    sleep_i = 1'b1;
    ctrl(mk(0, 2, 0, 0, 0));
    start();
    wait_n(8);
    chk(count_o == 16'd253, "R8 sleep ignored when hold clear", count_o, 253);
    sleep_i = 1'b0;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule